// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets synchronous logic read and write an external asynchronous static RAM of 128K bytes. The user side offers single-byte requests through a valid/ready handshake. A read returns its byte with a one-cycle valid pulse. On the memory side the block drives a 17-bit address and two chip selects of opposite polarity. It also drives an active-low write strobe, an active-low output enable, and a data bus split into an output value, a drive enable and an input value.

The memory's minimum times are parameters in nanoseconds, together with the clock period. Each time becomes a cycle count by rounding up, with a floor of one cycle. At the default 8 ns clock a read holds the strobes for 7 cycles and a write pulse lasts 6 cycles. After each write comes one turnaround cycle, in which the data bus is still driven while the device is deselected. Between accesses the device sits in standby: it is deselected and both strobes are high.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the device is deselected (mem_cs_n=1, mem_cs=0), mem_we_n=1, mem_oe_n=1, mem_dq_oe=0, req_ready=1 and rd_valid=0.
- R2: Whenever req_ready is high, the memory pins are in standby: mem_cs_n=1, mem_cs=0, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0.
- R3: A read accepted at a clock edge selects the device (mem_cs_n=0, mem_cs=1) with mem_we_n=1, mem_oe_n=0 and mem_dq_oe=0 for exactly NR cycles after that edge. NR is the largest of the rounded-up read cycle, address access, select access and enable access times (7 by default).
- R4: In the cycle after the last read-strobe cycle, rd_valid is 1 and rd_data holds the value mem_dq_in had in that last cycle. rd_valid is high for that single cycle only.
- R5: A write accepted at a clock edge selects the device and drops mem_we_n in the same cycle. mem_oe_n=1 and mem_dq_oe=1, with mem_dq_out holding the request data, for exactly NW cycles. NW is the largest of the rounded-up pulse, select-to-end, address-to-end and data-setup times and the write cycle time less one (6 by default).
- R6: A write ends with mem_we_n and both selects going inactive on the same edge. The data stays driven, unchanged, for one turnaround cycle and is then released.
- R7: req_ready is low from the accepting edge until the access ends, including the turnaround cycle. It is high again NR+1 cycles after a read is accepted and NW+2 cycles after a write is accepted.
- R8: mem_dq_oe is never high while mem_oe_n is low, and mem_oe_n is never low while mem_we_n is low.
- R9: mem_we_n is never low unless the device is selected.
- R10: A request presented while req_ready is low is ignored. The ongoing access keeps its address, data and length, and no access follows it.
- R11: mem_addr does not change while the device stays selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; a request is taken at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds read data |
| rd_data | output | 8 | Read data |
| mem_addr | output | 17 | Memory address |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data driven onto the memory bus |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data seen on the memory bus |

## Verification
Every result is tied to the edge that accepts the request. Read strobes occupy cycles 1 to NR after that edge, and rd_valid with its data is due in cycle NR+1. Write strobes occupy cycles 1 to NW, the turnaround falls in cycle NW+1, and ready returns in cycle NW+2. The bench samples each of these cycles on the falling edge and checks the strobes, address, data and ready. Its memory model presents the correct byte only in the last read-strobe cycle, and the complement in every other cycle, so a capture one cycle early or late returns the wrong data.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_TURN  = 2'd3
    } ctl_state_e;

    // Memory-side control levels, all as driven on the pins.
    typedef struct packed {
        logic cs_n;
        logic cs;
        logic we_n;
        logic oe_n;
        logic drive;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_STANDBY = '{cs_n: 1'b1, cs: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
    localparam pin_ctl_t PINS_READ    = '{cs_n: 1'b0, cs: 1'b1, we_n: 1'b1, oe_n: 1'b0, drive: 1'b0};
    localparam pin_ctl_t PINS_WRITE   = '{cs_n: 1'b0, cs: 1'b1, we_n: 1'b0, oe_n: 1'b1, drive: 1'b1};
    localparam pin_ctl_t PINS_TURN    = '{cs_n: 1'b1, cs: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b1};

    // Nanoseconds to whole cycles, rounded up, never below one.
    function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
    import asram_pkg::*;
#(
    parameter int NR = 7,
    parameter int NW = 6,
    parameter int CW = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  logic     req_write,
    output logic     accept,
    output logic     capture,
    output logic     idle,
    output pin_ctl_t pins
);
    ctl_state_e state_q;
    logic       last;
    logic [CW-1:0] load_val;

    assign idle     = (state_q == ST_IDLE);
    assign accept   = idle && req_valid;
    assign load_val = req_write ? CW'(NW) : CW'(NR);
    assign capture  = (state_q == ST_READ) && last;

    asram_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (load_val),
        .last     (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (req_valid) state_q <= req_write ? ST_WRITE : ST_READ;
                ST_READ:  if (last) state_q <= ST_IDLE;
                ST_WRITE: if (last) state_q <= ST_TURN;
                ST_TURN:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_READ:  pins = PINS_READ;
            ST_WRITE: pins = PINS_WRITE;
            ST_TURN:  pins = PINS_TURN;
            default:  pins = PINS_STANDBY;
        endcase
    end
endmodule

// File: rtl/asram_dp.sv
module asram_dp #(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] mem_dq_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata_q,
    output logic          rvalid_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture)
                rdata_q <= mem_dq_in;
            rvalid_q <= capture;
        end
    end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int AW     = 17,
    parameter int DW     = 8,
    parameter int CLK_NS = 8,
    parameter int T_RC   = 50,
    parameter int T_AA   = 50,
    parameter int T_ACS  = 50,
    parameter int T_OE   = 25,
    parameter int T_WC   = 50,
    parameter int T_WP   = 40,
    parameter int T_CW   = 45,
    parameter int T_AW   = 45,
    parameter int T_DW   = 25
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_cs,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam int NR = imax(imax(ns_to_cyc(T_RC, CLK_NS), ns_to_cyc(T_AA, CLK_NS)),
                             imax(ns_to_cyc(T_ACS, CLK_NS), ns_to_cyc(T_OE, CLK_NS)));
    localparam int WC_PULSE = imax(ns_to_cyc(T_WC, CLK_NS) - 1, 1);
    localparam int NW = imax(imax(ns_to_cyc(T_WP, CLK_NS), ns_to_cyc(T_CW, CLK_NS)),
                             imax(imax(ns_to_cyc(T_AW, CLK_NS), ns_to_cyc(T_DW, CLK_NS)), WC_PULSE));
    localparam int CW = $clog2(imax(NR, NW) + 1);

    logic     accept;
    logic     capture;
    logic     idle;
    pin_ctl_t pins;

    asram_fsm #(.NR(NR), .NW(NW), .CW(CW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .accept    (accept),
        .capture   (capture),
        .idle      (idle),
        .pins      (pins)
    );

    asram_dp #(.AW(AW), .DW(DW)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dq_in (mem_dq_in),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_out),
        .rdata_q   (rd_data),
        .rvalid_q  (rd_valid)
    );

    assign req_ready = idle;
    assign mem_cs_n  = pins.cs_n;
    assign mem_cs    = pins.cs;
    assign mem_we_n  = pins.we_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_dq_oe = pins.drive;
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready,
    input logic          rd_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_cs_n,
    input logic          mem_cs,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic [DW-1:0] mem_dq_out,
    input logic          mem_dq_oe
);
    a_r2_standby_when_ready: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe));

    a_r3_read_keeps_we_high: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_we_n && !mem_cs_n && mem_cs));

    a_r4_valid_is_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    a_r4_valid_follows_oe: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!mem_oe_n));

    a_r6_data_held_after_we: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_out) && mem_cs_n && !mem_cs));

    a_r7_busy_while_selected: assert property (@(posedge clk) disable iff (rst)
        !mem_cs_n |-> !req_ready);

    a_r8_no_drive_during_oe: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe);

    a_r9_we_needs_select: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_cs_n && mem_cs));

    a_r11_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_cs     (mem_cs),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;
    localparam int CLK_NS = 8;
    localparam int NR = (50 + CLK_NS - 1) / CLK_NS;   // 7
    localparam int NW = (45 + CLK_NS - 1) / CLK_NS;   // 6

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [16:0] mem_addr;
    logic        mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int oe_cnt = 0;
    logic [7:0] rd_model = 8'h00;
    logic [7:0] shadow [int];

    always #4 clk = ~clk;

    asram_ctrl uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    // Memory model: correct byte only in the final read-strobe cycle.
    always @(posedge clk) begin
        if (!mem_cs_n && mem_cs && !mem_oe_n) oe_cnt <= oe_cnt + 1;
        else oe_cnt <= 0;
    end
    assign mem_dq_in = (oe_cnt == NR - 1) ? rd_model : ~rd_model;

    function automatic logic [5:0] pins();
        return {mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe, req_ready};
    endfunction

    localparam logic [5:0] P_IDLE  = 6'b101101;
    localparam logic [5:0] P_READ  = 6'b011000;
    localparam logic [5:0] P_WRITE = 6'b010110;
    localparam logic [5:0] P_TURN  = 6'b101110;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] pattern(input logic [16:0] a);
        return a[7:0] ^ a[16:9] ^ 8'h5A;
    endfunction

    task automatic do_write(input logic [16:0] a, input logic [7:0] d, input bit noise);
        @(negedge clk);
        chk(pins() == P_IDLE, "R2 idle before write", 32'(pins()), 32'(P_IDLE));
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        if (noise) begin
            req_write = 1'b0; req_addr = ~a; req_wdata = ~d;   // R10: ignored while busy
        end else req_valid = 1'b0;
        for (int i = 1; i <= NW; i++) begin
            chk(pins() == P_WRITE, "R5 write strobes", 32'(pins()), 32'(P_WRITE));
            chk(mem_addr == a && mem_dq_out == d, "R5 R10 write addr/data",
                {mem_addr, 7'd0, mem_dq_out}, {a, 7'd0, d});
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(pins() == P_TURN, "R6 R7 turnaround", 32'(pins()), 32'(P_TURN));
        chk(mem_dq_out == d, "R6 data held", 32'(mem_dq_out), 32'(d));
        @(negedge clk);
        chk(pins() == P_IDLE, "R7 ready after NW+2", 32'(pins()), 32'(P_IDLE));
        shadow[int'(a)] = d;
    endtask

    task automatic do_read(input logic [16:0] a, input bit noise);
        logic [7:0] e;
        e = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
        @(negedge clk);
        chk(pins() == P_IDLE, "R2 idle before read", 32'(pins()), 32'(P_IDLE));
        rd_model = e;
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        if (noise) begin
            req_write = 1'b1; req_addr = ~a;   // R10: ignored while busy
        end else req_valid = 1'b0;
        for (int i = 1; i <= NR; i++) begin
            if (i == NR) req_valid = 1'b0;
            chk(pins() == P_READ && !rd_valid, "R3 R8 read strobes", 32'({rd_valid, pins()}), 32'(P_READ));
            chk(mem_addr == a, "R3 R11 read addr", 32'(mem_addr), 32'(a));
            @(negedge clk);
        end
        chk(rd_valid == 1'b1 && rd_data == e, "R4 read data", {23'd0, rd_valid, rd_data}, {23'd1, e});
        chk(pins() == P_IDLE, "R7 ready after NR+1", 32'(pins()), 32'(P_IDLE));
        @(negedge clk);
        chk(rd_valid == 1'b0 && pins() == P_IDLE, "R4 R10 single pulse, no extra access",
            32'({rd_valid, pins()}), 32'(P_IDLE));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [16:0] addrs [19];
        for (int i = 0; i < 17; i++) addrs[i] = 17'(1) << i;
        addrs[17] = 17'h00000;
        addrs[18] = 17'h1FFFF;

        repeat (3) @(negedge clk);
        chk(pins() == P_IDLE && !rd_valid, "R1 reset state", 32'({rd_valid, pins()}), 32'(P_IDLE));
        rst = 1'b0;
        @(negedge clk);
        chk(pins() == P_IDLE && !rd_valid, "R1 first cycle after reset", 32'({rd_valid, pins()}), 32'(P_IDLE));

        for (int i = 0; i < 19; i++) do_write(addrs[i], pattern(addrs[i]), (i % 2) == 1);
        for (int i = 18; i >= 0; i--) do_read(addrs[i], (i % 3) == 0);

        // back-to-back mixes with changing data
        for (int i = 0; i < 8; i++) begin
            logic [16:0] a;
            a = 17'(i * 16'h1357);
            do_write(a, 8'(i * 37 + 1), 1'b0);
            do_read(a, 1'b1);
            do_write(a, ~8'(i * 37 + 1), 1'b1);
            do_read(a, 1'b0);
        end

        finish_run();
    end
endmodule